// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and date as packed BCD fields: seconds, minutes, hours with an AM/PM flag, day of month, month, two-digit year and day of week. A one-cycle pulse on `tick_i` marks each elapsed second. While the run input is high, each accepted tick advances the count by one second. The carry ripples through every field, and month lengths and leap years are applied. Hours are counted either as 00 to 23 or on a 12-hour dial with a PM flag.

Software loads any single field through a small write port. It may do so only while `busy_o` is low. To read a consistent snapshot it raises `hold_i`. A tick that arrives during the hold is remembered and credited as one second once the hold drops. A one-cycle `adj_i` pulse snaps the seconds to a minute boundary, rounding to the nearest minute. Four one-cycle strobes mark each second, minute, hour and day rollover and can serve as interrupt sources.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read 00 s, 00 min, hour 00 with PM flag 0, day 01, month 01, year 00 and day of week 0. `busy_o` and all strobes are low.
- R2: With `busy_o` low, `wr_en_i` loads `wr_data_i` into the field chosen by `wr_sel_i`. The codes are 0 seconds [6:0], 1 minutes [6:0], 2 hour [5:0] plus PM flag from bit 7, 3 day [5:0], 4 month [4:0], 5 year [7:0], 6 day of week [2:0]. Code 7 changes nothing.
- R3: A tick accepted while running raises `busy_o` for exactly one cycle. The count changes only at the clock edge that ends the busy cycle. A write presented while `busy_o` is high is ignored.
- R4: While `run_i` is low, ticks are ignored: `busy_o` stays low and no field changes.
- R5: Seconds and minutes count BCD 00 to 59. The wrap of one carries into the next field.
- R6: In 24-hour mode (`mode24_i`=1) hours count 00 to 23. 23 wraps to 00 and advances the date. The PM flag is not altered by counting.
- R7: In 12-hour mode hours count 12, 01 ... 11. The step from 11 to 12 toggles the PM flag. The date advances only when that step clears the flag (PM to AM).
- R8: Day wraps to 01 after 31, 30 or 28/29 according to month. February has 29 days when the BCD year is a multiple of 4, 00 included. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R9: Day of week counts 0 to 6 and advances once on each date advance.
- R10: While `hold_i` is high, ticks change no field. When hold is released, exactly one second is added if any tick arrived during the hold, however many arrived.
- R11: An `adj_i` pulse with `busy_o` low takes one busy cycle. It sets seconds to 00, and if seconds were 30 or more it also advances the minute with full carry. A tick arriving together with the adjust is applied right after it.
- R12: One-cycle strobes appear together with the updated fields. The second strobe fires on each one-second advance. The minute strobe fires when seconds wrap, including an adjust carry. The hour strobe fires when minutes wrap, and the day strobe fires when the date advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per elapsed second |
| run_i | input | 1 | Enables counting |
| hold_i | input | 1 | Suspends counting, remembers a tick |
| mode24_i | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag |
| adj_i | input | 1 | Pulse: round seconds to nearest minute |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 3 | Field select code |
| wr_data_i | input | 8 | Field write data (BCD) |
| sec_o | output | 7 | Seconds, BCD |
| min_o | output | 7 | Minutes, BCD |
| hour_o | output | 6 | Hours, BCD |
| pm_o | output | 1 | PM flag |
| day_o | output | 6 | Day of month, BCD |
| month_o | output | 5 | Month, BCD |
| year_o | output | 8 | Year, BCD |
| dow_o | output | 3 | Day of week 0..6 |
| busy_o | output | 1 | Update in progress, writes ignored |
| sec_stb_o | output | 1 | Second advance strobe |
| min_stb_o | output | 1 | Minute rollover strobe |
| hour_stb_o | output | 1 | Hour rollover strobe |
| day_stb_o | output | 1 | Day rollover strobe |

## Verification
The range properties on seconds and day of week assume that software only writes legal BCD values. The bench only ever loads valid fields, drawn within each field's legal range. The day-rollover property assumes that `mode24_i` is steady around an update. The bench changes the mode only while loading a new state, never in the cycles around a tick. Random rounds start each time at a point a few seconds before an hour, day, month or year boundary in either hour mode, so that every carry path is driven.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
  localparam int NUM_FLD = 7;
  localparam int SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_DAY  = 3'd3,
    FLD_MON  = 3'd4,
    FLD_YEAR = 3'd5,
    FLD_DOW  = 3'd6,
    FLD_NONE = 3'd7
  } fld_e;

  function automatic logic [7:0] bcd_inc8(logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // multiple of 4: even tens with units 0/4/8, odd tens with units 2/6
  function automatic logic is_leap(logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [5:0] month_len(logic [4:0] m, logic leap);
    case (m)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcd_cal_sexa.sv
module bcd_cal_sexa (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       adj_i,
  input  logic       wr_i,
  input  logic [6:0] wr_val_i,
  output logic [6:0] val_o,
  output logic       carry_o
);
  logic [6:0] val_q, nxt;

  always_comb begin
    nxt     = val_q;
    carry_o = 1'b0;
    if (inc_i) begin
      if (val_q == 7'h59) begin
        nxt     = 7'h00;
        carry_o = 1'b1;
      end else if (val_q[3:0] == 4'd9) begin
        nxt = {val_q[6:4] + 3'd1, 4'd0};
      end else begin
        nxt = {val_q[6:4], val_q[3:0] + 4'd1};
      end
    end else if (adj_i) begin
      nxt     = 7'h00;
      carry_o = (val_q[6:4] >= 3'd3);
    end
    if (wr_i) nxt = wr_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) val_q <= '0;
    else         val_q <= nxt;

  assign val_o = val_q;
endmodule

// File: rtl/bcd_cal_hour.sv
module bcd_cal_hour (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       mode24_i,
  input  logic       wr_i,
  input  logic [5:0] wr_val_i,
  input  logic       wr_pm_i,
  output logic [5:0] val_o,
  output logic       pm_o,
  output logic       carry_o
);
  logic [5:0] val_q, nxt, step;
  logic       pm_q, pm_n;

  assign step = (val_q[3:0] == 4'd9) ? {val_q[5:4] + 2'd1, 4'd0}
                                     : {val_q[5:4], val_q[3:0] + 4'd1};

  always_comb begin
    nxt     = val_q;
    pm_n    = pm_q;
    carry_o = 1'b0;
    if (inc_i) begin
      if (mode24_i) begin
        if (val_q == 6'h23) begin
          nxt     = 6'h00;
          carry_o = 1'b1;
        end else begin
          nxt = step;
        end
      end else begin
        if (val_q == 6'h11) begin
          nxt     = 6'h12;
          pm_n    = ~pm_q;
          carry_o = pm_q;  // PM -> AM starts a new day
        end else if (val_q == 6'h12) begin
          nxt = 6'h01;
        end else begin
          nxt = step;
        end
      end
    end
    if (wr_i) begin
      nxt  = wr_val_i;
      pm_n = wr_pm_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      val_q <= '0;
      pm_q  <= 1'b0;
    end else begin
      val_q <= nxt;
      pm_q  <= pm_n;
    end

  assign val_o = val_q;
  assign pm_o  = pm_q;
endmodule

// File: rtl/bcd_cal_date.sv
module bcd_cal_date import bcd_cal_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       wr_day_i,
  input  logic       wr_mon_i,
  input  logic       wr_year_i,
  input  logic       wr_dow_i,
  input  logic [7:0] wr_data_i,
  output logic [5:0] day_o,
  output logic [4:0] mon_o,
  output logic [7:0] year_o,
  output logic [2:0] dow_o
);
  logic [5:0] day_q, day_n, last_day;
  logic [4:0] mon_q, mon_n;
  logic [7:0] year_q, year_n;
  logic [2:0] dow_q, dow_n;

  assign last_day = month_len(mon_q, is_leap(year_q));

  always_comb begin
    day_n  = day_q;
    mon_n  = mon_q;
    year_n = year_q;
    dow_n  = dow_q;
    if (inc_i) begin
      dow_n = (dow_q == 3'd6) ? 3'd0 : dow_q + 3'd1;
      if (day_q == last_day) begin
        day_n = 6'h01;
        if (mon_q == 5'h12) begin
          mon_n  = 5'h01;
          year_n = (year_q == 8'h99) ? 8'h00 : bcd_inc8(year_q);
        end else begin
          mon_n = (mon_q[3:0] == 4'd9) ? 5'h10 : {mon_q[4], mon_q[3:0] + 4'd1};
        end
      end else begin
        day_n = (day_q[3:0] == 4'd9) ? {day_q[5:4] + 2'd1, 4'd0}
                                     : {day_q[5:4], day_q[3:0] + 4'd1};
      end
    end
    if (wr_day_i)  day_n  = wr_data_i[5:0];
    if (wr_mon_i)  mon_n  = wr_data_i[4:0];
    if (wr_year_i) year_n = wr_data_i;
    if (wr_dow_i)  dow_n  = wr_data_i[2:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      day_q  <= 6'h01;
      mon_q  <= 5'h01;
      year_q <= 8'h00;
      dow_q  <= 3'd0;
    end else begin
      day_q  <= day_n;
      mon_q  <= mon_n;
      year_q <= year_n;
      dow_q  <= dow_n;
    end

  assign day_o  = day_q;
  assign mon_o  = mon_q;
  assign year_o = year_q;
  assign dow_o  = dow_q;
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar import bcd_cal_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic             mode24_i,
  input  logic             adj_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [7:0]       wr_data_i,
  output logic [6:0]       sec_o,
  output logic [6:0]       min_o,
  output logic [5:0]       hour_o,
  output logic             pm_o,
  output logic [5:0]       day_o,
  output logic [4:0]       month_o,
  output logic [7:0]       year_o,
  output logic [2:0]       dow_o,
  output logic             busy_o,
  output logic             sec_stb_o,
  output logic             min_stb_o,
  output logic             hour_stb_o,
  output logic             day_stb_o
);
  logic busy_q, op_inc_q, pend_q;
  logic adj_take, inc_take, step_inc, step_adj;
  logic sec_c, min_c, hour_c;
  logic [NUM_FLD-1:0] wr_hit;
  logic [3:0] stb_q;

  // requests are taken only between updates; a tick that cannot be taken stays pending
  assign adj_take = adj_i & ~busy_q;
  assign inc_take = ~busy_q & ~adj_take & run_i & ~hold_i & (tick_i | pend_q);
  assign step_inc = busy_q & op_inc_q;
  assign step_adj = busy_q & ~op_inc_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      op_inc_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      busy_q   <= adj_take | inc_take;
      op_inc_q <= inc_take;
      pend_q   <= run_i & ~inc_take & (pend_q | tick_i);
    end

  for (genvar g = 0; g < NUM_FLD; g++) begin : g_wr_dec
    assign wr_hit[g] = wr_en_i & ~busy_q & (wr_sel_i == SEL_W'(g));
  end

  bcd_cal_sexa u_sec (
    .clk_i, .rst_ni,
    .inc_i    (step_inc),
    .adj_i    (step_adj),
    .wr_i     (wr_hit[FLD_SEC]),
    .wr_val_i (wr_data_i[6:0]),
    .val_o    (sec_o),
    .carry_o  (sec_c)
  );

  bcd_cal_sexa u_min (
    .clk_i, .rst_ni,
    .inc_i    (sec_c),
    .adj_i    (1'b0),
    .wr_i     (wr_hit[FLD_MIN]),
    .wr_val_i (wr_data_i[6:0]),
    .val_o    (min_o),
    .carry_o  (min_c)
  );

  bcd_cal_hour u_hour (
    .clk_i, .rst_ni,
    .inc_i    (min_c),
    .mode24_i (mode24_i),
    .wr_i     (wr_hit[FLD_HOUR]),
    .wr_val_i (wr_data_i[5:0]),
    .wr_pm_i  (wr_data_i[7]),
    .val_o    (hour_o),
    .pm_o     (pm_o),
    .carry_o  (hour_c)
  );

  bcd_cal_date u_date (
    .clk_i, .rst_ni,
    .inc_i     (hour_c),
    .wr_day_i  (wr_hit[FLD_DAY]),
    .wr_mon_i  (wr_hit[FLD_MON]),
    .wr_year_i (wr_hit[FLD_YEAR]),
    .wr_dow_i  (wr_hit[FLD_DOW]),
    .wr_data_i (wr_data_i),
    .day_o     (day_o),
    .mon_o     (month_o),
    .year_o    (year_o),
    .dow_o     (dow_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) stb_q <= '0;
    else         stb_q <= {hour_c, min_c, sec_c, step_inc};

  assign busy_o     = busy_q;
  assign sec_stb_o  = stb_q[0];
  assign min_stb_o  = stb_q[1];
  assign hour_stb_o = stb_q[2];
  assign day_stb_o  = stb_q[3];
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       run_i,
  input logic       hold_i,
  input logic       mode24_i,
  input logic       adj_i,
  input logic       wr_en_i,
  input logic [6:0] sec_o,
  input logic [6:0] min_o,
  input logic [5:0] hour_o,
  input logic       pm_o,
  input logic [5:0] day_o,
  input logic [4:0] month_o,
  input logic [7:0] year_o,
  input logic [2:0] dow_o,
  input logic       busy_o,
  input logic       sec_stb_o,
  input logic       min_stb_o,
  input logic       hour_stb_o,
  input logic       day_stb_o
);
  logic [42:0] state;
  assign state = {sec_o, min_o, hour_o, pm_o, day_o, month_o, year_o, dow_o};

  AST_BUSY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o); // R3
  AST_IDLE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !wr_en_i) |=> $stable(state)); // R3
  AST_STOPPED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !adj_i) |=> !busy_o); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !adj_i && !busy_o) |=> !busy_o); // R10
  AST_SEC_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_o[3:0] <= 4'd9) && (sec_o[6:4] <= 3'd5)); // R5
  AST_MIN_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_stb_o |-> (sec_o == 7'h00)); // R11
  AST_DAY_AT_MIDNIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_stb_o && mode24_i) |-> (hour_o == 6'h00)); // R6
  AST_DOW_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dow_o <= 3'd6); // R9
  AST_HOUR_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hour_stb_o |-> min_stb_o); // R12
  AST_DAY_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_stb_o |-> hour_stb_o); // R12
  AST_STB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_stb_o |=> !sec_stb_o); // R12
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
  .clk_i, .rst_ni, .run_i, .hold_i, .mode24_i, .adj_i, .wr_en_i,
  .sec_o, .min_o, .hour_o, .pm_o, .day_o, .month_o, .year_o, .dow_o,
  .busy_o, .sec_stb_o, .min_stb_o, .hour_stb_o, .day_stb_o
);

// File: tb/bcd_calendar_test.sv
module bcd_calendar_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, run = 0, hold = 0, mode24 = 1, adj = 0, wr_en = 0;
  logic [2:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [6:0] sec_o, min_o;
  logic [5:0] hour_o, day_o;
  logic [4:0] month_o;
  logic [7:0] year_o;
  logic [2:0] dow_o;
  logic pm_o, busy_o, sec_stb_o, min_stb_o, hour_stb_o, day_stb_o;

  int checks = 0, failures = 0, cyc = 0;
  int m_sec = 0, m_min = 0, m_hr = 0, m_pm = 0, m_day = 1, m_mon = 1, m_yr = 0, m_dow = 0;
  bit e_s, e_m, e_h, e_d;

  always #10 clk = ~clk;

  bcd_calendar uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .run_i(run), .hold_i(hold),
    .mode24_i(mode24), .adj_i(adj), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .sec_o, .min_o, .hour_o, .pm_o, .day_o, .month_o, .year_o, .dow_o,
    .busy_o, .sec_stb_o, .min_stb_o, .hour_stb_o, .day_stb_o
  );

  function automatic logic [7:0] bcd(int n);
    return 8'((n / 10) * 16 + (n % 10));
  endfunction

  function automatic int dim(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [42:0] exp_state();
    logic [7:0] s = bcd(m_sec), mi = bcd(m_min), h = bcd(m_hr), d = bcd(m_day), mo = bcd(m_mon);
    return {s[6:0], mi[6:0], h[5:0], 1'(m_pm), d[5:0], mo[4:0], bcd(m_yr), 3'(m_dow)};
  endfunction

  task automatic day_adv();
    e_d = 1; m_dow = (m_dow + 1) % 7; m_day++;
    if (m_day > dim(m_mon, m_yr)) begin
      m_day = 1; m_mon++;
      if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
    end
  endtask

  task automatic min_adv();
    e_m = 1; m_min++;
    if (m_min == 60) begin
      m_min = 0; e_h = 1;
      if (mode24) begin
        m_hr++;
        if (m_hr == 24) begin m_hr = 0; day_adv(); end
      end else if (m_hr == 11) begin
        m_hr = 12;
        if (m_pm == 1) begin m_pm = 0; day_adv(); end else m_pm = 1;
      end else if (m_hr == 12) m_hr = 1;
      else m_hr++;
    end
  endtask

  task automatic m_second();
    {e_s, e_m, e_h, e_d} = 4'b1000;
    m_sec++;
    if (m_sec == 60) begin m_sec = 0; min_adv(); end
  endtask

  task automatic m_adjust();
    {e_s, e_m, e_h, e_d} = 4'b0000;
    if (m_sec >= 30) begin m_sec = 0; min_adv(); end else m_sec = 0;
  endtask

  task automatic check_state(string req);
    logic [42:0] act, ex;
    act = {sec_o, min_o, hour_o, pm_o, day_o, month_o, year_o, dow_o};
    ex = exp_state();
    checks++;
    if (act !== ex) begin
      failures++;
      $display("FAIL %s state act=%h exp=%h", req, act, ex);
    end
  endtask

  task automatic check_bits(string req, logic [3:0] act, logic [3:0] ex);
    checks++;
    if (act !== ex) begin
      failures++;
      $display("FAIL %s act=%b exp=%b", req, act, ex);
    end
  endtask

  task automatic wr(logic [2:0] s, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic load(bit m24, int y, int mo, int d, int h, int pm, int mi, int s, int w);
    @(negedge clk); mode24 = m24;
    wr(3'd0, bcd(s)); wr(3'd1, bcd(mi)); wr(3'd2, bcd(h) | (pm ? 8'h80 : 8'h00));
    wr(3'd3, bcd(d)); wr(3'd4, bcd(mo)); wr(3'd5, bcd(y)); wr(3'd6, 8'(w));
    m_yr = y; m_mon = mo; m_day = d; m_hr = h; m_pm = pm; m_min = mi; m_sec = s; m_dow = w;
  endtask

  // R3 busy then update on the following edge; R12 strobes with new values
  task automatic second(string req);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    check_bits({req, " R3 busy"}, {3'b0, busy_o}, 4'b0001);
    @(negedge clk);
    m_second();
    check_state(req);
    check_bits({req, " R12 strobes"}, {sec_stb_o, min_stb_o, hour_stb_o, day_stb_o}, {e_s, e_m, e_h, e_d});
  endtask

  task automatic adjust(string req);
    @(negedge clk); adj = 1;
    @(negedge clk); adj = 0;
    @(negedge clk);
    m_adjust();
    check_state(req);
    check_bits({req, " R12 adj strobes"}, {sec_stb_o, min_stb_o, hour_stb_o, day_stb_o}, {e_s, e_m, e_h, e_d});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_state("R1 reset");
    check_bits("R1 busy/strobes", {busy_o, sec_stb_o, min_stb_o, hour_stb_o | day_stb_o}, 4'b0000);

    // R4 stopped
    @(negedge clk); tick = 1; @(negedge clk); tick = 0;
    check_bits("R4 no busy", {3'b0, busy_o}, 4'b0000);
    @(negedge clk); check_state("R4 stopped");
    run = 1;

    // R2 writes and ignored select
    load(1, 24, 2, 28, 23, 0, 59, 58, 5);
    check_state("R2 load");
    wr(3'd7, 8'h11);
    @(negedge clk); check_state("R2 select 7");

    // R5 R6 R8 R9 leap February
    second("R5 sec");
    second("R8 leap feb29 R6 R9");
    load(1, 23, 2, 28, 23, 0, 59, 59, 6);
    second("R8 nonleap mar1 R9 wrap");
    load(1, 0, 2, 28, 23, 0, 59, 59, 0);
    second("R8 year00 leap");
    load(1, 99, 12, 31, 23, 0, 59, 59, 3);
    second("R8 year wrap");
    load(1, 10, 4, 30, 23, 1, 59, 59, 1);
    second("R6 pm untouched");

    // R7 12-hour dial
    load(0, 5, 3, 9, 11, 1, 59, 59, 2);
    second("R7 PM->AM day");
    load(0, 5, 3, 9, 11, 0, 59, 59, 2);
    second("R7 AM->PM");
    load(0, 5, 3, 19, 12, 1, 59, 59, 2);
    second("R7 12->01");

    // R3 write during busy ignored
    load(1, 1, 1, 1, 0, 0, 0, 10, 0);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0; wr_en = 1; wr_sel = 3'd0; wr_data = 8'h40;
    @(negedge clk); wr_en = 0;
    m_second();
    check_state("R3 write in busy ignored");

    // R10 hold with several ticks
    hold = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); tick = 1; @(negedge clk); tick = 0;
      check_bits("R10 no busy in hold", {3'b0, busy_o}, 4'b0000);
    end
    @(negedge clk); check_state("R10 frozen");
    hold = 0;
    @(negedge clk); @(negedge clk);
    m_second();
    check_state("R10 one credit");
    repeat (3) @(negedge clk);
    check_state("R10 no extra");

    // R11 adjust
    load(1, 30, 6, 30, 23, 0, 59, 29, 4);
    adjust("R11 below 30");
    load(1, 30, 6, 30, 23, 0, 59, 45, 4);
    adjust("R11 carry ripple");
    load(1, 30, 6, 30, 10, 0, 20, 30, 4);
    @(negedge clk); adj = 1; tick = 1;
    @(negedge clk); adj = 0; tick = 0;
    repeat (3) @(negedge clk);
    m_adjust(); m_second();
    check_state("R11 adjust then tick");

    // random near-boundary rounds
    for (int r = 0; r < 150; r++) begin
      bit m24 = 1'($urandom_range(0, 1));
      int y = $urandom_range(0, 99), mo = $urandom_range(1, 12);
      int d = dim(mo, y) - $urandom_range(0, 1);
      int h = m24 ? $urandom_range(22, 23) : $urandom_range(10, 12);
      load(m24, y, mo, d, h, $urandom_range(0, 1), 59, $urandom_range(55, 59), $urandom_range(0, 6));
      for (int k = 0; k < 6; k++) second("R5 R6 R7 R8 R9 random");
      if ($urandom_range(0, 3) == 0) adjust("R11 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule